// File: doc/BRIEF.md
# Host Port Interrupt Request Controller

This block sits on the processor side of an 8-bit host port. It owns one 8-bit control register and a 7-bit command vector register. The control register holds three interrupt enables, two general-purpose flags that the processor passes to the host, and a 3-bit host DMA mode field. Three status lines come in from the port: receive data full, transmit data empty and host command pending. The block ANDs each status line with its enable. It then picks one pending source by fixed priority and raises a registered interrupt request that carries a source code and a word-address vector.

The processor's interrupt logic takes the request and pulses `irq_ack_i` when it accepts it. The next pending source can then be granted. The two flags go out as the host-side status bits. The DMA mode field goes out together with a flag that says the host request lines act as interrupt requests.

Top module: `host_irq_ctrl`

## Requirements
- R1: While reset is low, the control register, the request and the flag mirror are all 0, so every interrupt is masked and DMA mode is off.
- R2: Control bit 0 enables the receive-data-full source. A receive request (source code 1) is only produced while `rx_full_i` is 1 and that bit is 1.
- R3: Control bit 1 enables the transmit-data-empty source. A transmit request (source code 2) is only produced while `tx_empty_i` is 1 and that bit is 1.
- R4: Control bit 2 enables the host-command source. A command request (source code 3) is only produced while `cmd_pend_i` is 1 and that bit is 1.
- R5: When several enabled sources are pending at a grant, the host command wins first, transmit comes second and receive comes last.
- R6: A command request carries the value that the command vector register held at the clock edge of the grant. Later writes to that register do not change a request that is already raised.
- R7: Receive and transmit requests carry the fixed vectors `RX_VEC` and `TX_VEC`.
- R8: A request rises on the clock edge after its enabled status is seen. Source and vector then stay constant while the source remains enabled and pending and no acknowledge arrives.
- R9: An acknowledge pulse clears the request at the next edge. The next pending source is granted on the edge after that.
- R10: Control bits 4:3 appear on `host_flag_o` one cycle after they are written into the control register.
- R11: Control bits 7:5 drive `dma_mode_o` from the write edge onward. `host_irq_mode_o` is 1 exactly when that field is 0.
- R12: A held request is withdrawn or replaced at the next edge once its status drops or its enable is cleared. The replacement is the highest-priority source still pending, or no request if none is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| cmd_vec_we_i | input | 1 | Command vector register write strobe |
| cmd_vec_wdata_i | input | 7 | Command vector write data (word address) |
| rx_full_i | input | 1 | Receive data full status |
| tx_empty_i | input | 1 | Transmit data empty status |
| cmd_pend_i | input | 1 | Host command pending status |
| irq_ack_i | input | 1 | Single-cycle acknowledge of the current request |
| irq_req_o | output | 1 | Registered interrupt request |
| irq_src_o | output | 2 | Granted source: 0 none, 1 receive, 2 transmit, 3 command |
| irq_vec_o | output | 7 | Vector word address of the granted source |
| host_flag_o | output | 2 | Processor-to-host flags as seen in the host status register |
| dma_mode_o | output | 3 | Host DMA mode field |
| host_irq_mode_o | output | 1 | High when DMA mode is off |

## Verification
The timing of each result is counted from the edge at which its stimulus is taken:
- Status and enable changes reach `irq_req_o`, `irq_src_o` and `irq_vec_o` one edge later.
- A control write takes effect for gating only from the edge after the write, so a grant that follows a write comes two edges after the strobe.
- `dma_mode_o` follows the write edge itself, and `host_flag_o` trails it by one more cycle.

The driver drives each cycle's inputs at the falling edge and queues the outputs expected after the coming rising edge. The monitor compares them 2 ns after that edge, so each check lands in the cycle these counts predict.

// File: rtl/host_irq_pkg.sv
package host_irq_pkg;
  localparam int NUM_SRC  = 3;
  localparam int CTL_W    = 8;
  localparam int EN_LSB   = 0;
  localparam int FLAG_LSB = 3;
  localparam int FLAG_W   = 2;
  localparam int DMA_LSB  = 5;
  localparam int DMA_W    = 3;

  // index order is priority order: higher index wins
  localparam int IDX_RX  = 0;
  localparam int IDX_TX  = 1;
  localparam int IDX_CMD = 2;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_RX   = 2'd1,
    SRC_TX   = 2'd2,
    SRC_CMD  = 2'd3
  } irq_src_e;
endpackage

// File: rtl/hirq_ctl_reg.sv
module hirq_ctl_reg
  import host_irq_pkg::*;
#(
  parameter int VEC_W = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctl_we_i,
  input  logic [CTL_W-1:0]    ctl_wdata_i,
  input  logic                vec_we_i,
  input  logic [VEC_W-1:0]    vec_wdata_i,
  output logic [CTL_W-1:0]    ctl_q_o,
  output logic [NUM_SRC-1:0]  en_o,
  output logic [DMA_W-1:0]    dma_mode_o,
  output logic                irq_mode_o,
  output logic [VEC_W-1:0]    cmd_vec_o,
  output logic [FLAG_W-1:0]   host_flag_o
);
  logic [CTL_W-1:0]  ctl_q;
  logic [VEC_W-1:0]  vec_q;
  logic [FLAG_W-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (ctl_we_i) begin
      ctl_q <= ctl_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= '0;
    end else if (vec_we_i) begin
      vec_q <= vec_wdata_i;
    end
  end

  // host-side mirror lags the register by one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
    end else begin
      flag_q <= ctl_q[FLAG_LSB +: FLAG_W];
    end
  end

  assign ctl_q_o     = ctl_q;
  assign en_o        = ctl_q[EN_LSB +: NUM_SRC];
  assign dma_mode_o  = ctl_q[DMA_LSB +: DMA_W];
  assign irq_mode_o  = (ctl_q[DMA_LSB +: DMA_W] == '0);
  assign cmd_vec_o   = vec_q;
  assign host_flag_o = flag_q;
endmodule

// File: rtl/hirq_arb.sv
module hirq_arb
  import host_irq_pkg::*;
#(
  parameter int N     = NUM_SRC,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     status_i,
  input  logic [N-1:0]     en_i,
  output logic [N-1:0]     gated_o,
  output logic             win_valid_o,
  output logic [IDX_W-1:0] win_idx_o
);
  for (genvar g = 0; g < N; g++) begin : g_gate
    assign gated_o[g] = status_i[g] & en_i[g];
  end

  // fixed priority, highest index first
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (gated_o[i]) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/hirq_req_reg.sv
module hirq_req_reg
  import host_irq_pkg::*;
#(
  parameter int             VEC_W  = 7,
  parameter logic [VEC_W-1:0] RX_VEC = 7'h20,
  parameter logic [VEC_W-1:0] TX_VEC = 7'h22,
  localparam int            IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] gated_i,
  input  logic               win_valid_i,
  input  logic [IDX_W-1:0]   win_idx_i,
  input  logic [VEC_W-1:0]   cmd_vec_i,
  input  logic               ack_i,
  output logic               req_o,
  output irq_src_e           src_o,
  output logic [VEC_W-1:0]   vec_o
);
  logic [VEC_W-1:0] vec_tbl [NUM_SRC];
  logic             req_q;
  irq_src_e         src_q;
  logic [VEC_W-1:0] vec_q;
  logic             hold_ok;

  assign vec_tbl[IDX_RX]  = RX_VEC;
  assign vec_tbl[IDX_TX]  = TX_VEC;
  assign vec_tbl[IDX_CMD] = cmd_vec_i;

  // held source still enabled and pending
  always_comb begin
    hold_ok = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req_q && (src_q == irq_src_e'(i + 1))) hold_ok = gated_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      src_q <= SRC_NONE;
      vec_q <= '0;
    end else if (ack_i) begin
      req_q <= 1'b0;
      src_q <= SRC_NONE;
    end else if (!hold_ok) begin
      req_q <= win_valid_i;
      if (win_valid_i) begin
        src_q <= irq_src_e'(win_idx_i + 1'b1);
        vec_q <= vec_tbl[win_idx_i];
      end else begin
        src_q <= SRC_NONE;
      end
    end
  end

  assign req_o = req_q;
  assign src_o = src_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/host_irq_ctrl.sv
module host_irq_ctrl
  import host_irq_pkg::*;
#(
  parameter int               VEC_W  = 7,
  parameter logic [VEC_W-1:0] RX_VEC = 7'h20,
  parameter logic [VEC_W-1:0] TX_VEC = 7'h22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [7:0]       ctl_wdata_i,
  input  logic             cmd_vec_we_i,
  input  logic [VEC_W-1:0] cmd_vec_wdata_i,
  input  logic             rx_full_i,
  input  logic             tx_empty_i,
  input  logic             cmd_pend_i,
  input  logic             irq_ack_i,
  output logic             irq_req_o,
  output logic [1:0]       irq_src_o,
  output logic [VEC_W-1:0] irq_vec_o,
  output logic [1:0]       host_flag_o,
  output logic [2:0]       dma_mode_o,
  output logic             host_irq_mode_o
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [CTL_W-1:0]   ctl_q;
  logic [NUM_SRC-1:0] en;
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] gated;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  logic [VEC_W-1:0]   cmd_vec_q;
  irq_src_e           src;

  assign status[IDX_RX]  = rx_full_i;
  assign status[IDX_TX]  = tx_empty_i;
  assign status[IDX_CMD] = cmd_pend_i;

  hirq_ctl_reg #(.VEC_W(VEC_W)) i_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_we_i    (ctl_we_i),
    .ctl_wdata_i (ctl_wdata_i),
    .vec_we_i    (cmd_vec_we_i),
    .vec_wdata_i (cmd_vec_wdata_i),
    .ctl_q_o     (ctl_q),
    .en_o        (en),
    .dma_mode_o  (dma_mode_o),
    .irq_mode_o  (host_irq_mode_o),
    .cmd_vec_o   (cmd_vec_q),
    .host_flag_o (host_flag_o)
  );

  hirq_arb #(.N(NUM_SRC)) i_arb (
    .status_i    (status),
    .en_i        (en),
    .gated_o     (gated),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx)
  );

  hirq_req_reg #(.VEC_W(VEC_W), .RX_VEC(RX_VEC), .TX_VEC(TX_VEC)) i_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gated_i     (gated),
    .win_valid_i (win_valid),
    .win_idx_i   (win_idx),
    .cmd_vec_i   (cmd_vec_q),
    .ack_i       (irq_ack_i),
    .req_o       (irq_req_o),
    .src_o       (src),
    .vec_o       (irq_vec_o)
  );

  assign irq_src_o = src;
endmodule

// File: rtl/hirq_chk.sv
module hirq_chk #(
  parameter int VEC_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       ctl_q,
  input logic [VEC_W-1:0] cmd_vec_q,
  input logic             rx_full_i,
  input logic             tx_empty_i,
  input logic             cmd_pend_i,
  input logic             irq_ack_i,
  input logic             irq_req_o,
  input logic [1:0]       irq_src_o,
  input logic [VEC_W-1:0] irq_vec_o,
  input logic [1:0]       host_flag_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!irq_req_o && ctl_q == 8'h00 && host_flag_o == 2'b00));

  // R2
  rx_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && irq_src_o == 2'd1) |-> $past(rx_full_i && ctl_q[0]));

  // R3
  tx_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && irq_src_o == 2'd2) |-> $past(tx_empty_i && ctl_q[1]));

  // R4
  cmd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && irq_src_o == 2'd3) |-> $past(cmd_pend_i && ctl_q[2]));

  // R5
  cmd_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_req_o && !irq_ack_i && cmd_pend_i && ctl_q[2])
      |=> (irq_req_o && irq_src_o == 2'd3));

  // R5
  tx_over_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_req_o && !irq_ack_i && tx_empty_i && ctl_q[1] && !(cmd_pend_i && ctl_q[2]))
      |=> (irq_req_o && irq_src_o == 2'd2));

  // R6
  cmd_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_req_o) && irq_src_o == 2'd3) |-> (irq_vec_o == $past(cmd_vec_q)));

  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && !irq_ack_i && irq_src_o == 2'd3 && cmd_pend_i && ctl_q[2])
      |=> (irq_req_o && $stable(irq_src_o) && $stable(irq_vec_o)));

  // R9
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_i |=> !irq_req_o);

  // R10
  flag_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (host_flag_o == $past(ctl_q[4:3])));
endmodule

bind host_irq_ctrl hirq_chk #(.VEC_W(VEC_W)) i_hirq_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_q       (ctl_q),
  .cmd_vec_q   (cmd_vec_q),
  .rx_full_i   (rx_full_i),
  .tx_empty_i  (tx_empty_i),
  .cmd_pend_i  (cmd_pend_i),
  .irq_ack_i   (irq_ack_i),
  .irq_req_o   (irq_req_o),
  .irq_src_o   (irq_src_o),
  .irq_vec_o   (irq_vec_o),
  .host_flag_o (host_flag_o)
);

// File: tb/test_host_irq_ctrl.sv
module test_host_irq_ctrl;
  localparam logic [6:0] RXV = 7'h20;
  localparam logic [6:0] TXV = 7'h22;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctl_we_i = 1'b0;
  logic [7:0] ctl_wdata_i = '0;
  logic       cmd_vec_we_i = 1'b0;
  logic [6:0] cmd_vec_wdata_i = '0;
  logic       rx_full_i = 1'b0;
  logic       tx_empty_i = 1'b0;
  logic       cmd_pend_i = 1'b0;
  logic       irq_ack_i = 1'b0;
  logic       irq_req_o;
  logic [1:0] irq_src_o;
  logic [6:0] irq_vec_o;
  logic [1:0] host_flag_o;
  logic [2:0] dma_mode_o;
  logic       host_irq_mode_o;

  always #4 clk_i = ~clk_i;

  host_irq_ctrl i_host_irq_ctrl (
    .clk_i, .rst_ni, .ctl_we_i, .ctl_wdata_i, .cmd_vec_we_i, .cmd_vec_wdata_i,
    .rx_full_i, .tx_empty_i, .cmd_pend_i, .irq_ack_i,
    .irq_req_o, .irq_src_o, .irq_vec_o, .host_flag_o, .dma_mode_o, .host_irq_mode_o
  );

  typedef struct {
    string      tag;
    bit         chk_irq;
    bit         req;
    logic [1:0] src;
    logic [6:0] vec;
    logic [1:0] flag;
    logic [2:0] dma;
  } exp_t;

  exp_t       q[$];
  int         n_run = 0;
  int         n_fail = 0;
  logic [7:0] mdl_ctl = '0;
  bit         done = 1'b0;

  // driver: push outputs expected after the coming rising edge
  task automatic cyc(string tag, bit ci, bit r, logic [1:0] s, logic [6:0] v);
    exp_t e;
    e.tag = tag; e.chk_irq = ci; e.req = r; e.src = s; e.vec = v;
    e.flag = mdl_ctl[4:3];
    if (ctl_we_i) mdl_ctl = ctl_wdata_i;
    e.dma = mdl_ctl[7:5];
    q.push_back(e);
    @(negedge clk_i);
    ctl_we_i = 1'b0; cmd_vec_we_i = 1'b0; irq_ack_i = 1'b0;
  endtask

  task automatic fail(string tag, string what, int act, int exp);
    n_fail++;
    $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        if (e.chk_irq) begin
          n_run++;
          if (irq_req_o !== e.req) fail(e.tag, "req", irq_req_o, e.req);
          else if (e.req && irq_src_o !== e.src) fail(e.tag, "src", irq_src_o, e.src);
          else if (e.req && irq_vec_o !== e.vec) fail(e.tag, "vec", irq_vec_o, e.vec);
        end
        n_run++;
        if (host_flag_o !== e.flag) fail({e.tag, "/R10"}, "flag", host_flag_o, e.flag);
        n_run++;
        if (dma_mode_o !== e.dma) fail({e.tag, "/R11"}, "dma", dma_mode_o, e.dma);
        n_run++;
        if (host_irq_mode_o !== (e.dma == 3'd0))
          fail({e.tag, "/R11"}, "irq_mode", host_irq_mode_o, int'(e.dma == 3'd0));
      end
    end
  end

  initial begin
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    cyc("R1 reset state", 1, 0, 0, 0);
    rx_full_i = 1; tx_empty_i = 1; cmd_pend_i = 1;
    cyc("R2 R3 R4 all masked", 1, 0, 0, 0);
    cyc("R4 masked hold", 1, 0, 0, 0);
    cmd_vec_we_i = 1; cmd_vec_wdata_i = 7'h35;
    cyc("R4 vec write only", 1, 0, 0, 0);
    ctl_we_i = 1; ctl_wdata_i = 8'h01;
    cyc("R8 no grant on write edge", 1, 0, 0, 0);
    cyc("R2 R7 rx grant", 1, 1, 2'd1, RXV);
    ctl_we_i = 1; ctl_wdata_i = 8'h07;
    cyc("R8 rx held", 1, 1, 2'd1, RXV);
    irq_ack_i = 1;
    cyc("R9 ack clears", 1, 0, 0, 0);
    cyc("R5 R6 cmd wins", 1, 1, 2'd3, 7'h35);
    cmd_vec_we_i = 1; cmd_vec_wdata_i = 7'h11;
    cyc("R6 vec latched", 1, 1, 2'd3, 7'h35);
    irq_ack_i = 1;
    cyc("R9 ack cmd", 1, 0, 0, 0);
    cmd_pend_i = 0;
    cyc("R5 R7 tx over rx", 1, 1, 2'd2, TXV);
    tx_empty_i = 0;
    cyc("R12 tx drop to rx", 1, 1, 2'd1, RXV);
    ctl_we_i = 1; ctl_wdata_i = 8'h06;
    cyc("R12 rx held on mask edge", 1, 1, 2'd1, RXV);
    cyc("R12 R2 rx masked drop", 1, 0, 0, 0);
    cmd_pend_i = 1;
    cyc("R6 new cmd vector", 1, 1, 2'd3, 7'h11);
    irq_ack_i = 1; ctl_we_i = 1; ctl_wdata_i = 8'h00;
    cyc("R9 ack with mask", 1, 0, 0, 0);
    cyc("R4 cmd masked", 1, 0, 0, 0);
    ctl_we_i = 1; ctl_wdata_i = 8'hB0;
    cyc("R11 dma on", 1, 0, 0, 0);
    cyc("R10 flag mirror", 1, 0, 0, 0);
    ctl_we_i = 1; ctl_wdata_i = 8'h0A;
    cyc("R11 dma off", 1, 0, 0, 0);
    cyc("R10 flag mirror 2", 1, 0, 0, 0);
    rx_full_i = 1; tx_empty_i = 1; cmd_pend_i = 1;
    cyc("R3 tx only enabled", 1, 1, 2'd2, TXV);
    cyc("R8 tx held", 1, 1, 2'd2, TXV);
    @(negedge clk_i);
    @(negedge clk_i);
    done = 1'b1;
  end

  initial begin
    int cnt = 0;
    while (!done && cnt < 5000) begin
      @(posedge clk_i);
      cnt++;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule